// File: doc/BRIEF.md
# Sign-Corrected Byte Multiplier

This unit performs byte multiplication for a small 8-bit processor datapath. An unsigned array forms the full 16-bit product of two operands in one clock. The result is kept in a pair of byte registers, one for the upper byte and one for the lower byte, and each can be read on its own. The unit has no status flag outputs. It reports only the product and a one-cycle completion pulse.

For two's-complement operands, the unit does not use a signed array. It loads the unsigned product first. It then corrects only the upper byte over two further cycles.

- In the first correction cycle, if the second operand is negative, the first operand is subtracted from the upper byte, modulo 256.
- In the second correction cycle, if the first operand is negative, the second operand is subtracted from the upper byte, modulo 256.

Each correction cycle is spent whether or not a subtraction happens, so the signed latency is fixed. A start request is accepted only while the unit is idle. Operands and mode are captured at the edge where the request is accepted.

Top module: `mulfix_unit`

## Requirements
- R1: After reset, `prodHi` and `prodLo` read 0x00 and `doneFlag` is low.
- R2: With `signedMode` = 0, {`prodHi`,`prodLo`} equals the unsigned product of `opA` and `opB`.
- R3: An unsigned operation sets `doneFlag` and the final product in the first clock edge after its start is accepted. Unsigned operations can therefore be started back to back every cycle.
- R4: With `signedMode` = 1, {`prodHi`,`prodLo`} equals the 16-bit two's-complement product of `opA` and `opB` read as signed bytes.
- R5: A signed operation raises `doneFlag` exactly at the third clock edge after acceptance. `doneFlag` stays low at the first two edges, for every combination of operand signs.
- R6: The signed correction never changes `prodLo`. In both modes `prodLo` equals the low byte of the unsigned operand product.
- R7: A `startReq` that arrives while a signed correction is in progress is ignored. The running operation's result and timing are unchanged.
- R8: `doneFlag` is high for one cycle per operation. The product registers keep their value while no operation runs.
- R9: Operands and mode are captured at the accepting edge. Later changes on `opA`, `opB` or `signedMode` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a multiply; accepted only when idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| prodHi | output | 8 | Upper byte of the product |
| prodLo | output | 8 | Lower byte of the product |
| doneFlag | output | 1 | One-cycle pulse when the product registers hold the final value |

## Verification
A fault in the correction sequencer appears at the ports within three cycles of acceptance. Typical faults are a skipped or repeated correction step, the wrong operand subtracted, or a misread sign bit. Any of these leaves a wrong upper byte when `doneFlag` rises, or moves the `doneFlag` pulse earlier or later. A sequencer that reopens for a new start while still busy would show the junk operands in the result of the running operation. Every unsigned operand pair is covered exhaustively, and signed pairs are drawn at random around the corner values. Together these expose wrong partial sums in either byte within one to three cycles of acceptance.

// File: rtl/mulfix_pkg.sv
package mulfix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIXB = 2'd1,
    ST_FIXA = 2'd2
  } mulState_e;

  typedef struct packed {
    logic load;   // capture operands and the unsigned product
    logic fixB;   // correction step tied to the sign of operand B
    logic fixA;   // correction step tied to the sign of operand A
  } mulStrobe_t;

endpackage

// File: rtl/mulfix_ctrl.sv
module mulfix_ctrl
  import mulfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       signedMode,
  output mulStrobe_t strobes,
  output logic       doneFlag
);

  mulState_e state;
  mulState_e stateNext;

  always_comb begin
    strobes.load = startReq && (state == ST_IDLE);
    strobes.fixB = (state == ST_FIXB);
    strobes.fixA = (state == ST_FIXA);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobes.load && signedMode) stateNext = ST_FIXB;
      ST_FIXB: stateNext = ST_FIXA;
      ST_FIXA: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      doneFlag <= 1'b0;
    end else begin
      state    <= stateNext;
      doneFlag <= (strobes.load && !signedMode) || strobes.fixA;
    end
  end

  // R3: unsigned operation completes at the next edge
  a_r3_unsigned_latency: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !signedMode) |=> doneFlag);

  // R5: signed operation completes exactly at the third edge
  a_r5_signed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && signedMode) |=> !doneFlag ##1 !doneFlag ##1 doneFlag);

  // R8: a signed completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !strobes.load) |=> !doneFlag);

endmodule

// File: rtl/mulfix_dpath.sv
module mulfix_dpath
  import mulfix_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobe_t      strobes,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] prodHi,
  output logic [OP_W-1:0] prodLo
);

  localparam int PROD_W = 2 * OP_W;

  logic [OP_W-1:0]   regA;
  logic [OP_W-1:0]   regB;
  logic [PROD_W-1:0] rawProd;

  assign rawProd = {{OP_W{1'b0}}, opA} * {{OP_W{1'b0}}, opB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      prodHi <= '0;
      prodLo <= '0;
    end else if (strobes.load) begin
      regA   <= opA;
      regB   <= opB;
      prodHi <= rawProd[PROD_W-1:OP_W];
      prodLo <= rawProd[OP_W-1:0];
    end else if (strobes.fixB) begin
      if (regB[OP_W-1]) prodHi <= prodHi - regA;
    end else if (strobes.fixA) begin
      if (regA[OP_W-1]) prodHi <= prodHi - regB;
    end
  end

  // R6: correction leaves the low byte alone
  a_r6_lo_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fixB || strobes.fixA) |=> $stable(prodLo));

  // R6: low byte equals the low half of the operand product after a load
  a_r6_lo_product: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (prodLo == OP_W'($past(opA) * $past(opB))));

  // R7 / R9: captured operands do not move while a correction runs
  a_r7_operands_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fixB || strobes.fixA) |=> ($stable(regA) && $stable(regB)));

  // R8: product registers hold while nothing runs
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.fixB && !strobes.fixA) |=> $stable({prodHi, prodLo}));

endmodule

// File: rtl/mulfix_unit.sv
module mulfix_unit
  import mulfix_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            signedMode,
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] prodHi,
  output logic [OP_W-1:0] prodLo,
  output logic            doneFlag
);

  mulStrobe_t strobes;

  mulfix_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .signedMode (signedMode),
    .strobes    (strobes),
    .doneFlag   (doneFlag)
  );

  mulfix_dpath #(.OP_W(OP_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .prodHi  (prodHi),
    .prodLo  (prodLo)
  );

endmodule

// File: tb/mulfix_unit_bench.sv
module mulfix_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       signedMode = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] prodHi;
  logic [7:0] prodLo;
  logic       doneFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mulfix_unit u_mulfix_unit (
    .clk(clk), .rstN(rstN), .startReq(startReq), .signedMode(signedMode),
    .opA(opA), .opB(opB), .prodHi(prodHi), .prodLo(prodLo), .doneFlag(doneFlag)
  );

  function automatic logic [15:0] expUns(input logic [7:0] a, input logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction

  function automatic logic [15:0] expSgn(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] sa;
    logic signed [15:0] sb;
    sa = 16'($signed(a));
    sb = 16'($signed(b));
    return 16'(sa * sb);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      summary();
    end
  end

  // Unsigned op: called at a negedge, returns at the next negedge with results checked.
  task automatic runUns(input logic [7:0] a, input logic [7:0] b);
    opA = a; opB = b; signedMode = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    opA = 8'($urandom); opB = 8'($urandom);  // R9: late changes ignored
    chk("R3 done", 16'(doneFlag), 16'd1);
    chk("R2 product", {prodHi, prodLo}, expUns(a, b));
  endtask

  // Signed op: optionally pokes start with junk operands while busy (R7).
  task automatic runSgn(input logic [7:0] a, input logic [7:0] b, input bit poke);
    opA = a; opB = b; signedMode = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = poke;
    opA = 8'($urandom); opB = 8'($urandom); signedMode = 1'($urandom); // R9
    chk("R5 done early1", 16'(doneFlag), 16'd0);
    chk("R6 lo", 16'(prodLo), 16'(expUns(a, b) & 16'hff));
    @(negedge clk);
    opA = 8'($urandom); opB = 8'($urandom);
    chk("R5 done early2", 16'(doneFlag), 16'd0);
    @(negedge clk);
    startReq = 1'b0;
    chk("R5 done", 16'(doneFlag), 16'd1);
    chk(poke ? "R7 product" : "R4 product", {prodHi, prodLo}, expSgn(a, b));
    chk("R6 lo after fix", 16'(prodLo), 16'(expUns(a, b) & 16'hff));
  endtask

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset hi/lo", {prodHi, prodLo}, 16'h0000);
    chk("R1 reset done", 16'(doneFlag), 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {prodHi, prodLo}, 16'h0000);

    // Directed signed corners, every sign combination
    runSgn(8'h80, 8'h80, 1'b0);
    runSgn(8'hff, 8'hff, 1'b0);
    runSgn(8'h7f, 8'h80, 1'b0);
    runSgn(8'h80, 8'h7f, 1'b0);
    runSgn(8'h00, 8'hff, 1'b0);
    runSgn(8'h05, 8'h03, 1'b1);
    runSgn(8'hfb, 8'h03, 1'b1);

    // R8: pulse drops and product holds while idle
    held = {prodHi, prodLo};
    @(negedge clk);
    chk("R8 done drops", 16'(doneFlag), 16'd0);
    repeat (3) @(negedge clk);
    chk("R8 hold", {prodHi, prodLo}, held);

    runUns(8'hff, 8'hff);
    runUns(8'h00, 8'h00);
    runUns(8'h80, 8'h02);
    @(negedge clk);
    chk("R8 done drops uns", 16'(doneFlag), 16'd0);

    // Exhaustive unsigned, back to back (R2, R3)
    for (int i = 0; i < 65536; i++) runUns(8'(i >> 8), 8'(i));

    // Random signed, with random busy pokes (R4, R5, R7)
    for (int i = 0; i < 20000; i++) runSgn(8'($urandom), 8'($urandom), 1'($urandom));

    // Mixed modes back to back
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 2 == 0) runUns(8'($urandom), 8'($urandom));
      else runSgn(8'($urandom), 8'($urandom), 1'b0);
    end

    summary();
  end

endmodule